// File: doc/BRIEF.md
# Half-Duplex Command/Response Serial Master

This block is the master side of a three-wire half-duplex serial link. A frame begins when software or a neighbouring controller pulses `start_i`. The block then pulls the active-low frame select low, shifts out an 8-bit command on `sdo_o`, leaves one serial clock period idle so the slave can turn the line around, and then clocks in a reply whose length is set by `reply_len_i`. During the reply the block drives nothing useful on `sdo_o` and holds it low.

The serial clock is derived from the system clock. Each serial period is a low half followed by a high half, and each half lasts `HALF_DIV` system clocks. The block changes its outgoing data as the serial clock falls (the first command bit appears as the frame opens) and samples incoming reply bits as the serial clock rises. At the end of the frame the received word appears right-aligned on `rx_word_o`, together with a one-cycle `done_o` pulse.

A frame with reply length L takes 9 + L serial periods: 8 command periods, one turnaround period and L reply periods, which gives 13 to 25 serial clocks. A start request that arrives while a frame is in progress is dropped.

Top module: `mw_cmd_master`

## Requirements
- R1: After reset `cs_n_o` is 1, `sclk_o` is 0, `sdo_o` is 0 and `done_o` is 0.
- R2: Serial periods 0 to 7 of a frame carry the command on `sdo_o`, most significant bit first. Bit 7 is present from the cycle the frame opens, and each later bit changes only at a falling edge of `sclk_o`.
- R3: `sdi_i` is not captured during the command periods or the turnaround period. It has no effect on `rx_word_o`.
- R4: Period 8 is a turnaround period with no data exchanged. `sdo_o` is 0 from period 8 to the end of the frame.
- R5: `reply_len_i` (5 bits) is sampled only when a frame starts. Values 4 to 16 set the reply length L directly, values below 4 give L = 4, and values above 16 give L = 16.
- R6: `cs_n_o` stays low for exactly 2·HALF_DIV·(9+L) system clocks per frame. Each serial period is low for HALF_DIV system clocks and then high for HALF_DIV system clocks.
- R7: `sclk_o` is 0 whenever `cs_n_o` is 1, and a frame contains exactly 9+L rising edges of `sclk_o`.
- R8: Reply bits are sampled from `sdi_i` at the rising edges of periods 9 to 8+L, most significant bit first. They appear in `rx_word_o[L-1:0]` with all upper bits 0. `done_o` is 1 for exactly one system clock, which is the first cycle in which `cs_n_o` is high again.
- R9: A `start_i` pulse while `cs_n_o` is low is ignored. It neither alters nor extends the current frame and does not start another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start request, one system clock |
| cmd_i | input | CMD_W | Command word, latched at start |
| reply_len_i | input | LEN_W | Requested reply length, latched at start |
| sdi_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock, idle low |
| cs_n_o | output | 1 | Frame select, active low |
| sdo_o | output | 1 | Serial data to the slave |
| rx_word_o | output | MAX_LEN | Received reply, right-aligned |
| done_o | output | 1 | One-cycle pulse when the reply is complete |

## Verification
The assertions assume that `start_i` is a synchronous level and that `reply_len_i` may take any 5-bit value. They do not assume that the slave keeps `sdi_i` quiet outside the reply. The bench sweeps every length code from 0 to 20, plus 31, against several command patterns. It drives `sdi_i` high throughout the command and turnaround periods, so any stray capture would show up in the upper bits of the reply. It also changes `cmd_i` and `reply_len_i` right after each start, and in some frames it pulses `start_i` again halfway through the frame.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic {
        MW_IDLE = 1'b0,
        MW_RUN  = 1'b1
    } mw_mode_e;
endpackage

// File: rtl/mw_half_tick.sv
module mw_half_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q == CW'(HALF_DIV - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mw_shift_seq.sv
module mw_shift_seq
    import mw_pkg::*;
#(
    parameter int CMD_W   = 8,
    parameter int MIN_LEN = 4,
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [CMD_W-1:0]   cmd_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               sdi_i,
    input  logic               tick_i,
    output logic               run_o,
    output logic               sclk_o,
    output logic               cs_n_o,
    output logic               sdo_o,
    output logic [MAX_LEN-1:0] rx_word_o,
    output logic               done_o
);
    localparam int PER_W = $clog2(CMD_W + MAX_LEN + 2);

    typedef struct packed {
        mw_mode_e           mode;
        logic               sclk;
        logic               cs_n;
        logic               sdo;
        logic               done;
        logic [CMD_W-1:0]   cmd_sh;
        logic [MAX_LEN-1:0] rx_sh;
        logic [MAX_LEN-1:0] rx_word;
        logic [LEN_W-1:0]   len;
        logic [PER_W-1:0]   per;
    } seq_t;

    seq_t s_d, s_q;
    logic [LEN_W-1:0] len_clamped;
    logic [PER_W-1:0] last_per;
    logic [PER_W-1:0] next_per;

    always_comb begin
        if (len_i < LEN_W'(MIN_LEN))      len_clamped = LEN_W'(MIN_LEN);
        else if (len_i > LEN_W'(MAX_LEN)) len_clamped = LEN_W'(MAX_LEN);
        else                              len_clamped = len_i;
    end

    assign last_per = PER_W'(CMD_W) + PER_W'(s_q.len);
    assign next_per = s_q.per + 1'b1;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.mode == MW_IDLE) begin
            if (start_i) begin
                s_d.mode   = MW_RUN;
                s_d.cs_n   = 1'b0;
                s_d.sclk   = 1'b0;
                s_d.sdo    = cmd_i[CMD_W-1];
                s_d.cmd_sh = cmd_i << 1;
                s_d.rx_sh  = '0;
                s_d.len    = len_clamped;
                s_d.per    = '0;
            end
        end else if (tick_i) begin
            if (!s_q.sclk) begin
                s_d.sclk = 1'b1;
                if (s_q.per > PER_W'(CMD_W))
                    s_d.rx_sh = {s_q.rx_sh[MAX_LEN-2:0], sdi_i};
            end else begin
                s_d.sclk = 1'b0;
                if (s_q.per == last_per) begin
                    s_d.mode    = MW_IDLE;
                    s_d.cs_n    = 1'b1;
                    s_d.sdo     = 1'b0;
                    s_d.done    = 1'b1;
                    s_d.rx_word = s_q.rx_sh;
                end else begin
                    s_d.per = next_per;
                    if (next_per < PER_W'(CMD_W)) begin
                        s_d.sdo    = s_q.cmd_sh[CMD_W-1];
                        s_d.cmd_sh = s_q.cmd_sh << 1;
                    end else begin
                        s_d.sdo = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= MW_IDLE;
            s_q.cs_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_o     = (s_q.mode == MW_RUN);
    assign sclk_o    = s_q.sclk;
    assign cs_n_o    = s_q.cs_n;
    assign sdo_o     = s_q.sdo;
    assign rx_word_o = s_q.rx_word;
    assign done_o    = s_q.done;

    // R7
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cs_n |-> !s_q.sclk);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    // R8
    done_at_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.cs_n) |-> s_q.done);

    // R4
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.cs_n && s_q.per >= PER_W'(CMD_W)) |-> !s_q.sdo);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.cs_n && start_i) |=> $stable(s_q.len));

    // R5
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.cs_n |-> (s_q.len >= LEN_W'(MIN_LEN) && s_q.len <= LEN_W'(MAX_LEN)));

    // R3
    rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.cs_n && s_q.per <= PER_W'(CMD_W)) |-> (s_q.rx_sh == '0));
endmodule

// File: rtl/mw_cmd_master.sv
module mw_cmd_master #(
    parameter int HALF_DIV = 4,
    parameter int CMD_W    = 8,
    parameter int MIN_LEN  = 4,
    parameter int MAX_LEN  = 16,
    parameter int LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [CMD_W-1:0]   cmd_i,
    input  logic [LEN_W-1:0]   reply_len_i,
    input  logic               sdi_i,
    output logic               sclk_o,
    output logic               cs_n_o,
    output logic               sdo_o,
    output logic [MAX_LEN-1:0] rx_word_o,
    output logic               done_o
);
    logic run_w;
    logic tick_w;

    mw_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_w),
        .tick_o (tick_w)
    );

    mw_shift_seq #(
        .CMD_W   (CMD_W),
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .cmd_i     (cmd_i),
        .len_i     (reply_len_i),
        .sdi_i     (sdi_i),
        .tick_i    (tick_w),
        .run_o     (run_w),
        .sclk_o    (sclk_o),
        .cs_n_o    (cs_n_o),
        .sdo_o     (sdo_o),
        .rx_word_o (rx_word_o),
        .done_o    (done_o)
    );
endmodule

// File: tb/mw_cmd_master_tb.sv
`timescale 1ns/1ps
module mw_cmd_master_tb;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cmd = '0;
    logic [4:0]  rlen = '0;
    logic        sdi = 1'b1;
    logic        sclk, cs_n, sdo, done;
    logic [15:0] rx_word;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mw_cmd_master #(.HALF_DIV(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd),
        .reply_len_i(rlen), .sdi_i(sdi), .sclk_o(sclk), .cs_n_o(cs_n),
        .sdo_o(sdo), .rx_word_o(rx_word), .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [7:0] c, input int len, input bit poke);
        int eff, low, rises, falls, done_n, quiet_bad, idle_bad, after;
        logic [15:0] reply, rxv;
        logic [7:0] got;
        logic prev;
        eff = (len < 4) ? 4 : ((len > 16) ? 16 : len);
        reply = 16'((c * 37 + len * 13) ^ 16'hA5C3) & 16'((1 << eff) - 1);
        @(negedge clk);
        start = 1'b1; cmd = c; rlen = 5'(len); sdi = 1'b1;
        @(negedge clk);
        start = 1'b0; cmd = ~c; rlen = 5'd7;
        low = 0; rises = 0; falls = 0; done_n = 0; quiet_bad = 0;
        idle_bad = 0; after = 0; got = '0; rxv = '0; prev = 1'b0;
        for (int i = 0; i < 4000 && after < 4; i++) begin
            if (!cs_n) low++;
            if (sclk && !prev) begin
                rises++;
                if (rises <= 8) got = {got[6:0], sdo};
                else if (sdo) quiet_bad++;
            end
            if (!sclk && prev) begin
                falls++;
                if (falls >= 9 && falls - 9 < eff) sdi = reply[eff - 1 - (falls - 9)];
                else sdi = 1'b1;
            end
            if (cs_n && sclk) idle_bad++;
            if (done) begin done_n++; rxv = rx_word; end
            if (cs_n && low > 0) after++;
            start = poke && (low == 30);
            prev = sclk;
            @(negedge clk);
        end
        start = 1'b0;
        // R2 command bits MSB first
        chk(got == c, "R2 command", int'(got), int'(c));
        // R3 R8 reply right-aligned, no stray capture
        chk(rxv == reply, "R3/R8 reply word", int'(rxv), int'(reply));
        // R7 rising edge count
        chk(rises == 9 + eff, "R7 sclk rises", rises, 9 + eff);
        // R6 R9 frame length in system clocks
        chk(low == 2 * HALF * (9 + eff), "R6/R9 cs_n low cycles", low, 2 * HALF * (9 + eff));
        // R8 done single pulse
        chk(done_n == 1, "R8 done pulses", done_n, 1);
        // R4 sdo quiet after command
        chk(quiet_bad == 0, "R4 sdo quiet", quiet_bad, 0);
        // R7 sclk low while idle
        chk(idle_bad == 0, "R7 sclk idle", idle_bad, 0);
        // R5 length latched at start (rlen changed to 7 right after)
        if (len != 7) chk(rises != 16, "R5 length latched", rises, 9 + eff);
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] cmds [4];
        cmds[0] = 8'hA5; cmds[1] = 8'h00; cmds[2] = 8'hFF; cmds[3] = 8'h3C;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1, "R1 cs_n reset", int'(cs_n), 1);
        chk(sclk == 1'b0, "R1 sclk reset", int'(sclk), 0);
        chk(sdo == 1'b0,  "R1 sdo reset",  int'(sdo), 0);
        chk(done == 1'b0, "R1 done reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int l = 0; l <= 21; l++) begin
            for (int k = 0; k < 4; k++) begin
                // R9 second start mid-frame on pattern 3
                run_frame(cmds[k] ^ 8'(l), (l == 21) ? 31 : l, k == 3);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule